// File: doc/BRIEF.md
# Oversampled Serial Character Receiver with Break Detection

This block turns an asynchronous serial line into characters. It runs from a one-cycle oversampling enable (`tick`) that arrives `OVS` times per bit period. On each enable it samples an already-synchronized receive line and assembles one character. A character has a low start bit, 5 to 8 data bits sent least-significant first, an optional parity bit and one stop bit. The baud-rate generator and any receive FIFO sit outside the block.

For each character the block raises `out_valid` for one clock. In that cycle it presents the data together with parity-error, framing-error and break flags. A low stop bit is not treated as an idle gap. That low level is taken as the start bit of the next character, and assembly continues at once. A line held low for a whole character yields a single break character. After that the receiver ignores the line until it returns high.

Top module: `serrx_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_valid`, `out_data`, `out_perr`, `out_ferr` and `out_brk` are all 0.
- R2: A low sample on a tick in idle starts a character. The start bit is checked again `OVS/2` ticks later. If the line is high then, the receiver returns to idle and emits nothing.
- R3: Data bits are sampled every `OVS` ticks after the start check, least-significant bit first. `cfg_wlen` values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits. Unused upper bits of `out_data` are 0.
- R4: When `cfg_par_en` is 1, one parity bit follows the data. `out_perr` is set when that bit differs from the expected value. `cfg_par_sel` selects the expected value: 0 odd (data plus parity has an odd number of ones), 1 even, 2 constant 1, 3 constant 0. When `cfg_par_en` is 0, no parity bit is taken and `out_perr` is 0.
- R5: A stop-bit sample of 0 sets `out_ferr` for that character.
- R6: After a framing error, the low stop-bit sample serves as a confirmed start bit. The next data bit is sampled `OVS` ticks later, with no new falling edge needed.
- R7: When the start, data, parity (if enabled) and stop samples are all 0, the block emits one character with `out_data` 0, `out_brk` 1, `out_ferr` 1 and `out_perr` 0.
- R8: After a break character, no further character is emitted while the line stays low. After the line returns to 1, a later falling edge starts a new character normally.
- R9: `out_valid` is high for exactly one clock per character. The data and flags are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, OVS pulses per bit |
| rxd | input | 1 | Synchronized serial receive line |
| cfg_wlen | input | 2 | Data bits: 0..3 gives 5..8 |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_sel | input | 2 | Parity kind: 0 odd, 1 even, 2 constant 1, 3 constant 0 |
| out_valid | output | 1 | One-cycle character strobe |
| out_data | output | DW | Received data, right-aligned |
| out_perr | output | 1 | Parity error |
| out_ferr | output | 1 | Framing error |
| out_brk | output | 1 | Break character |

## Verification
The bench builds the block with its defaults: `OVS` = 16 and `DW` = 8. It drives one tick every second clock, so the start check lands 8 ticks after the edge, and a missed or extra tick moves every later sample across a bit boundary. With `DW` = 8, all four word lengths and every parity kind are reachable, including an 8-bit data field whose top bit must line up exactly. Directed cases cover a start-bit glitch, back-to-back framing errors with resynchronization, and a break lasting several character times followed by a clean character.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_BRKW  = 3'd5
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_ODD  = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ONE  = 2'd2,
    PAR_ZERO = 2'd3
  } par_mode_e;
endpackage

// File: rtl/serrx_shift.sv
module serrx_shift #(
  parameter int DW  = 8,
  localparam int NBW = $clog2(DW + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           shift_en,
  input  logic           din,
  input  logic [NBW-1:0] nbits,
  output logic [DW-1:0]  data_out
);
  logic [DW-1:0]  sh_q;
  logic [NBW-1:0] sft;

  always_ff @(posedge clk) begin
    if (rst || clr) sh_q <= '0;
    else if (shift_en) sh_q <= {din, sh_q[DW-1:1]};
  end

  assign sft      = NBW'(DW) - nbits;
  assign data_out = sh_q >> sft;
endmodule

// File: rtl/serrx_parity.sv
module serrx_parity #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic [1:0]    mode,
  output logic          exp_bit
);
  import serrx_pkg::*;
  always_comb begin
    case (par_mode_e'(mode))
      PAR_ODD:  exp_bit = ~(^data);
      PAR_EVEN: exp_bit = ^data;
      PAR_ONE:  exp_bit = 1'b1;
      default:  exp_bit = 1'b0;
    endcase
  end
endmodule

// File: rtl/serrx_top.sv
module serrx_top #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_wlen,
  input  logic          cfg_par_en,
  input  logic [1:0]    cfg_par_sel,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_perr,
  output logic          out_ferr,
  output logic          out_brk
);
  import serrx_pkg::*;

  localparam int CW   = $clog2(OVS);
  localparam int NBW  = $clog2(DW + 1);
  localparam int MINW = DW - 3;
  localparam logic [CW-1:0] HALF_M1 = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] LAST    = CW'(OVS - 1);

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [NBW-1:0] bitn_q;
  logic           zero_q;
  logic           par_q;
  logic [NBW-1:0] nbits;
  logic [DW-1:0]  sh_data;
  logic           exp_par;
  logic           at_last, start_ok, resync, shift_en;

  assign nbits    = NBW'(MINW) + NBW'(cfg_wlen);
  assign at_last  = tick && (cnt_q == LAST);
  assign start_ok = tick && (state_q == S_START) && (cnt_q == HALF_M1) && !rxd;
  assign resync   = at_last && (state_q == S_STOP) && !rxd && !zero_q;
  assign shift_en = at_last && (state_q == S_DATA);

  serrx_shift #(.DW(DW)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clr      (start_ok || resync),
    .shift_en (shift_en),
    .din      (rxd),
    .nbits    (nbits),
    .data_out (sh_data)
  );

  serrx_parity #(.DW(DW)) u_par (
    .data    (sh_data),
    .mode    (cfg_par_sel),
    .exp_bit (exp_par)
  );

  always_ff @(posedge clk) begin
    out_valid <= 1'b0;
    if (rst) begin
      state_q  <= S_IDLE;
      cnt_q    <= '0;
      bitn_q   <= '0;
      zero_q   <= 1'b1;
      par_q    <= 1'b0;
      out_data <= '0;
      out_perr <= 1'b0;
      out_ferr <= 1'b0;
      out_brk  <= 1'b0;
    end else if (tick) begin
      case (state_q)
        S_IDLE: begin
          if (!rxd) begin
            state_q <= S_START;
            cnt_q   <= '0;
          end
        end
        S_START: begin
          if (cnt_q == HALF_M1) begin
            cnt_q <= '0;
            if (!rxd) begin
              state_q <= S_DATA;
              bitn_q  <= '0;
              zero_q  <= 1'b1;
            end else begin
              state_q <= S_IDLE;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_DATA: begin
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            bitn_q <= bitn_q + 1'b1;
            if (rxd) zero_q <= 1'b0;
            if (bitn_q == nbits - 1'b1)
              state_q <= cfg_par_en ? S_PAR : S_STOP;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_PAR: begin
          if (cnt_q == LAST) begin
            cnt_q   <= '0;
            par_q   <= rxd;
            state_q <= S_STOP;
            if (rxd) zero_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_STOP: begin
          if (cnt_q == LAST) begin
            cnt_q     <= '0;
            out_valid <= 1'b1;
            if (rxd) begin
              out_data <= sh_data;
              out_perr <= cfg_par_en && (par_q != exp_par);
              out_ferr <= 1'b0;
              out_brk  <= 1'b0;
              state_q  <= S_IDLE;
            end else if (zero_q) begin
              out_data <= '0;
              out_perr <= 1'b0;
              out_ferr <= 1'b1;
              out_brk  <= 1'b1;
              state_q  <= S_BRKW;
            end else begin
              out_data <= sh_data;
              out_perr <= cfg_par_en && (par_q != exp_par);
              out_ferr <= 1'b1;
              out_brk  <= 1'b0;
              state_q  <= S_DATA;
              bitn_q   <= '0;
              zero_q   <= 1'b1;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_BRKW: begin
          if (rxd) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serrx_chk.sv
module serrx_chk #(
  parameter int OVS = 16,
  parameter int DW  = 8,
  localparam int CW = $clog2(OVS)
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  tick,
  input logic                  rxd,
  input logic                  cfg_par_en,
  input logic                  out_valid,
  input logic [DW-1:0]         out_data,
  input logic                  out_perr,
  input logic                  out_ferr,
  input logic                  out_brk,
  input serrx_pkg::rx_state_e  state,
  input logic [CW-1:0]         cnt
);
  import serrx_pkg::*;

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid && !out_brk && !out_ferr); // R1

  AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state == S_START && tick && rxd && cnt == CW'(OVS / 2 - 1)) |=> (state == S_IDLE)); // R2

  AST_NOPAR_NOPERR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(cfg_par_en)) |-> !out_perr); // R4

  AST_BRK_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_brk) |-> (out_ferr && !out_perr && out_data == '0)); // R7

  AST_BRKW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == S_BRKW && tick && !rxd) |=> (state == S_BRKW)); // R8

  AST_BRKW_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state == S_BRKW && $past(state == S_BRKW)) |-> !out_valid); // R8

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R9
endmodule

bind serrx_top serrx_chk #(.OVS(OVS), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .rxd        (rxd),
  .cfg_par_en (cfg_par_en),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_perr   (out_perr),
  .out_ferr   (out_ferr),
  .out_brk    (out_brk),
  .state      (state_q),
  .cnt        (cnt_q)
);

// File: tb/serrx_top_tb_top.sv
module serrx_top_tb_top;
  localparam int OVS = 16;
  localparam int DW  = 8;
  localparam int TD  = 2;

  logic clk = 0, rst = 1, tick = 0, rxd = 1;
  logic [1:0] cfg_wlen = 2'd3, cfg_par_sel = 2'd0;
  logic cfg_par_en = 0;
  logic out_valid, out_perr, out_ferr, out_brk;
  logic [DW-1:0] out_data;

  int checks = 0, errors = 0, div = 0;
  logic prev_v = 0;
  logic [DW+2:0] expq[$];
  logic [DW+2:0] gotq[$];

  always #5 clk = ~clk;

  serrx_top #(.OVS(OVS), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
    .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_sel(cfg_par_sel),
    .out_valid(out_valid), .out_data(out_data), .out_perr(out_perr),
    .out_ferr(out_ferr), .out_brk(out_brk)
  );

  always @(negedge clk) begin
    tick <= (div == TD - 1);
    div  <= (div == TD - 1) ? 0 : div + 1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid && prev_v) begin
        errors++;
        $display("FAIL R9 strobe longer than one cycle actual 2 expected 1");
      end
      if (out_valid) begin
        checks++;
        gotq.push_back({out_brk, out_ferr, out_perr, out_data});
      end
    end
    prev_v <= out_valid;
  end

  function automatic logic exp_parity(input logic [DW-1:0] d, input logic [1:0] sel);
    case (sel)
      2'd0: return ~(^d);
      2'd1: return ^d;
      2'd2: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
  endtask

  task automatic drive(input logic v, input int nt);
    @(negedge clk);
    rxd = v;
    wait_ticks(nt);
  endtask

  task automatic send_body(input logic [DW-1:0] d, input int nb, input logic pbit);
    for (int i = 0; i < nb; i++) drive(d[i], OVS);
    if (cfg_par_en) drive(pbit, OVS);
  endtask

  task automatic check_all(input string req);
    checks++;
    if (gotq.size() != expq.size()) begin
      errors++;
      $display("FAIL %s count actual %0d expected %0d", req, gotq.size(), expq.size());
    end else begin
      foreach (expq[i]) begin
        checks++;
        if (gotq[i] !== expq[i]) begin
          errors++;
          $display("FAIL %s char %0d actual %h expected %h", req, i, gotq[i], expq[i]);
        end
      end
    end
    gotq.delete();
    expq.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R9 actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed = 32'h5EED_1234;
    logic [DW-1:0] d;
    logic pb, bad;
    int nb;
    void'($urandom(seed));
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_data !== 0 || out_perr !== 0 || out_ferr !== 0 || out_brk !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs actual %b%h%b%b%b expected all zero",
               out_valid, out_data, out_perr, out_ferr, out_brk);
    end
    rst = 0;
    drive(1, 2 * OVS);

    // R2: short low glitch must not start a character
    drive(0, 3);
    drive(1, 2 * OVS);
    check_all("R2");

    // R3: all word lengths, no parity
    for (int w = 0; w < 4; w++) begin
      cfg_wlen = 2'(w); cfg_par_en = 0; nb = 5 + w;
      d = 8'hB5 & 8'((1 << nb) - 1);
      drive(0, OVS); send_body(d, nb, 0); drive(1, 2 * OVS);
      expq.push_back({3'b000, d});
    end
    check_all("R3");

    // R4: every parity kind, correct and wrong
    for (int s = 0; s < 4; s++) begin
      cfg_wlen = 2'd3; cfg_par_en = 1; cfg_par_sel = 2'(s);
      for (int f = 0; f < 2; f++) begin
        d = 8'h6C ^ 8'(s);
        pb = exp_parity(d, cfg_par_sel) ^ f[0];
        drive(0, OVS); send_body(d, 8, pb); drive(1, 2 * OVS);
        expq.push_back({2'b00, f[0], d});
      end
    end
    check_all("R4");

    // R5 and R6: bad stop bit, next character resyncs from it
    cfg_wlen = 2'd3; cfg_par_en = 0;
    drive(0, OVS); send_body(8'hA1, 8, 0); drive(0, OVS);
    send_body(8'h3C, 8, 0); drive(0, OVS);
    send_body(8'h81, 8, 0); drive(1, 2 * OVS);
    expq.push_back({3'b010, 8'hA1});
    expq.push_back({3'b010, 8'h3C});
    expq.push_back({3'b000, 8'h81});
    check_all("R5 R6");

    // R7 and R8: long break, then a clean character
    cfg_wlen = 2'd2; cfg_par_en = 1; cfg_par_sel = 2'd2;
    drive(0, 4 * 11 * OVS);
    expq.push_back({3'b110, 8'h00});
    check_all("R7 R8 single break char");
    drive(1, OVS);
    d = 8'h55 & 8'h7F;
    drive(0, OVS); send_body(d, 7, exp_parity(d, 2'd2)); drive(1, 2 * OVS);
    expq.push_back({3'b000, d});
    check_all("R8 after break");

    // R3 R4 R9: random frames
    for (int k = 0; k < 60; k++) begin
      cfg_wlen = 2'($urandom_range(0, 3));
      cfg_par_en = 1'($urandom_range(0, 1));
      cfg_par_sel = 2'($urandom_range(0, 3));
      nb = 5 + int'(cfg_wlen);
      d = 8'($urandom) & 8'((1 << nb) - 1);
      bad = ($urandom_range(0, 3) == 0);
      pb = exp_parity(d, cfg_par_sel) ^ bad;
      drive(0, OVS); send_body(d, nb, pb); drive(1, OVS + $urandom_range(0, OVS));
      expq.push_back({2'b00, cfg_par_en & bad, d});
    end
    drive(1, OVS);
    check_all("R3 R4 R9 random");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule